// File: doc/BRIEF.md
# Frame-Synchronous PCM Tone Inserter

This block drives one serial time-division PCM output. A frame holds 32 timeslots of 8 bits each, and the output carries one bit per clock, most significant bit first. An upstream source provides the sample byte for the current timeslot, and the block tells it which timeslot that is. Two per-slot masks control the output. The first mask picks the slots in which the block drives the line. The second mask marks the slots that belong to an enabled conference.

A tone request and a square-wave frequency input are captured only at the active-low frame pulse. While the captured request is high, every conference slot carries a fixed tone code instead of its sample. The tone level is one tenth of full scale. Its sign follows the captured square-wave level, so every slot carries the same tone sample for the whole frame. A select input chooses A-law or µ-law codes, and each is sent with the usual line inversion for that law. In unselected slots the output enable is low, which stands for a high-impedance line.

Top module: `pcm_tone_ins`

## Requirements
- R1: While the captured tone request is 0, each selected slot carries its `pcm_in` byte unchanged.
- R2: While the captured tone request is 1, selected slots with `conf_en[s]`=1 carry the tone code. Selected slots with `conf_en[s]`=0 carry their `pcm_in` byte.
- R3: `tone_dur` and `tone_freq` are sampled only on clock edges where `frame_n`=0. Changes between frame pulses have no effect on the current frame.
- R4: A captured `tone_freq` of 1 selects the positive tone code. A captured 0 selects the negative tone code.
- R5: With `law_sel`=0 (A-law), the tone codes on the line are 0x9C (positive) and 0x1C (negative). These are the magnitude codes 0xC9 and 0x49 with the even bits inverted (XOR 0x55).
- R6: With `law_sel`=1 (µ-law), the tone codes on the line are 0xB5 (positive) and 0x35 (negative). These are the codes 0x4A and 0xCA with all bits inverted.
- R7: A clock edge with `frame_n`=0 restarts the count at slot 0, bit 0, and `slot_idx` steps every 8 clocks. Bit b (0 = MSB) of slot s appears on `ser_out` in the clock that follows the (8s+b+1)-th edge after the pulse edge.
- R8: `ser_oe` is 1 for all 8 bits of slot s exactly when `chan_sel[s]`=1. Otherwise it is 0.
- R9: While `rst` is high, `ser_oe` and `ser_out` are 0, the captured tone request is cleared and the count is held at slot 0, bit 0. The cycle after reset acts as the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame pulse, one clock wide |
| tone_dur | input | 1 | Tone request, captured at the frame pulse |
| tone_freq | input | 1 | Square-wave level, captured at the frame pulse |
| law_sel | input | 1 | 0 = A-law, 1 = µ-law |
| chan_sel | input | 32 | Per-slot output drive enable |
| conf_en | input | 32 | Per-slot membership in an enabled conference |
| pcm_in | input | 8 | Sample byte for the slot shown on slot_idx |
| slot_idx | output | 5 | Current timeslot number |
| ser_out | output | 1 | Serial PCM data, MSB first |
| ser_oe | output | 1 | Output enable; 0 means the line is high-impedance |

## Verification
Some properties are checked on every clock. The output enable may change only at a slot boundary, and it falls on reset. The frame pulse must bring the count back to zero. The captured tone state must stay constant between pulses. Any slot byte that is switched to tone must be one of the two codes for the selected law.

The bench scenarios cover what the clocked properties cannot show. They check the exact code values and the sign chosen by the square-wave input. They check MSB-first bit placement and which slots pass data untouched. They confirm that toggling the tone inputs after the pulse has no effect, and that reset clears a tone that was latched before it.

// File: rtl/pcm_tone_pkg.sv
package pcm_tone_pkg;

    typedef enum logic {
        LAW_A  = 1'b0,
        LAW_MU = 1'b1
    } law_e;

    typedef logic [7:0] pcm_byte_t;

    typedef struct packed {
        logic active;   // tone replaces conference data this frame
        logic positive; // sign of the tone sample this frame
    } tone_state_t;

    // Segment/mantissa for one tenth of full scale (sign bit cleared)
    localparam pcm_byte_t A_MAG  = 8'h49;
    localparam pcm_byte_t MU_MAG = 8'h4A;

    function automatic pcm_byte_t line_mask(law_e law);
        return (law == LAW_A) ? 8'h55 : 8'hFF;
    endfunction

    // A-law marks positive with sign 1, mu-law with sign 0 (before inversion)
    function automatic pcm_byte_t tone_code(law_e law, logic positive);
        pcm_byte_t raw;
        if (law == LAW_A) raw = {positive, A_MAG[6:0]};
        else              raw = {~positive, MU_MAG[6:0]};
        return raw ^ line_mask(law);
    endfunction

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
    parameter int NSLOT = 32,
    parameter int BITS  = 8,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int BIT_W  = $clog2(BITS),
    localparam int CNT_W  = SLOT_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              first_bit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSLOT * BITS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !frame_n)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign slot_idx  = cnt[CNT_W-1:BIT_W];
    assign first_bit = (cnt[BIT_W-1:0] == '0);

    // R7
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (slot_idx == '0 && first_bit));

endmodule

// File: rtl/pcm_tone_latch.sv
module pcm_tone_latch
    import pcm_tone_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        tone_dur,
    input  logic        tone_freq,
    output tone_state_t tone
);
    always_ff @(posedge clk) begin
        if (rst)          tone <= '0;
        else if (!frame_n) tone <= '{active: tone_dur, positive: tone_freq};
    end

    // R3
    tone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        frame_n |=> $stable(tone));

endmodule

// File: rtl/pcm_tone_mux.sv
module pcm_tone_mux
    import pcm_tone_pkg::*;
(
    input  tone_state_t tone,
    input  law_e        law,
    input  logic        conf_hit,
    input  pcm_byte_t   pcm_in,
    output pcm_byte_t   slot_byte
);
    always_comb begin
        if (tone.active && conf_hit) slot_byte = tone_code(law, tone.positive);
        else                         slot_byte = pcm_in;
    end
endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            first_bit,
    input  logic            chan_on,
    input  logic [BITS-1:0] load_byte,
    output logic            ser_out,
    output logic            ser_oe
);
    logic [BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            ser_out <= 1'b0;
            ser_oe  <= 1'b0;
        end else if (first_bit) begin
            shreg   <= {load_byte[BITS-2:0], 1'b0};
            ser_out <= load_byte[BITS-1];
            ser_oe  <= chan_on;
        end else begin
            shreg   <= {shreg[BITS-2:0], 1'b0};
            ser_out <= shreg[BITS-1];
        end
    end

    // R8
    oe_slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !first_bit |=> $stable(ser_oe));

    // R9
    oe_reset_chk: assert property (@(posedge clk)
        rst |=> (!ser_oe && !ser_out));

endmodule

// File: rtl/pcm_tone_ins.sv
module pcm_tone_ins
    import pcm_tone_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int BITS  = 8,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              tone_dur,
    input  logic              tone_freq,
    input  logic              law_sel,
    input  logic [NSLOT-1:0]  chan_sel,
    input  logic [NSLOT-1:0]  conf_en,
    input  logic [7:0]        pcm_in,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              ser_out,
    output logic              ser_oe
);
    logic        first_bit;
    tone_state_t tone;
    pcm_byte_t   slot_byte;
    law_e        law;

    assign law = law_e'(law_sel);

    pcm_slot_timer #(.NSLOT(NSLOT), .BITS(BITS)) timer_i (
        .clk(clk), .rst(rst), .frame_n(frame_n),
        .slot_idx(slot_idx), .first_bit(first_bit)
    );

    pcm_tone_latch latch_i (
        .clk(clk), .rst(rst), .frame_n(frame_n),
        .tone_dur(tone_dur), .tone_freq(tone_freq), .tone(tone)
    );

    pcm_tone_mux mux_i (
        .tone(tone), .law(law), .conf_hit(conf_en[slot_idx]),
        .pcm_in(pcm_in), .slot_byte(slot_byte)
    );

    pcm_serializer #(.BITS(8)) ser_i (
        .clk(clk), .rst(rst), .first_bit(first_bit),
        .chan_on(chan_sel[slot_idx]), .load_byte(slot_byte),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    // R2
    tone_code_chk: assert property (@(posedge clk) disable iff (rst)
        (tone.active && conf_en[slot_idx]) |->
        (slot_byte == tone_code(law, 1'b1) || slot_byte == tone_code(law, 1'b0)));

endmodule

// File: tb/pcm_tone_ins_tb.sv
`timescale 1ns/1ps
module pcm_tone_ins_tb_top;

    logic        clk = 1'b0;
    logic        rst, frame_n, tone_dur, tone_freq, law_sel;
    logic [31:0] chan_sel, conf_en;
    logic [7:0]  pcm_in, seed;
    logic [4:0]  slot_idx;
    logic        ser_out, ser_oe;
    int          checks = 0;
    int          errors = 0;
    logic [255:0] oe_cap, out_cap;

    always #4 clk = ~clk;

    pcm_tone_ins dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .tone_dur(tone_dur),
        .tone_freq(tone_freq), .law_sel(law_sel), .chan_sel(chan_sel),
        .conf_en(conf_en), .pcm_in(pcm_in), .slot_idx(slot_idx),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    function automatic logic [7:0] data_for(logic [4:0] s, logic [7:0] sd);
        return sd ^ {s, 3'b011};
    endfunction

    always_comb pcm_in = data_for(slot_idx, seed);

    typedef struct packed {
        logic        td;
        logic        tf;
        logic        law;
        logic [31:0] conf;
        logic [31:0] chan;
        logic [7:0]  sd;
        logic [7:0]  code;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h11, 8'h9C},
        '{1'b1, 1'b1, 1'b0, 32'h0000_FFFF, 32'hFFFF_FFFF, 8'h22, 8'h9C},
        '{1'b1, 1'b0, 1'b0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 8'h5A, 8'h1C},
        '{1'b1, 1'b1, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 8'hC3, 8'hB5},
        '{1'b1, 1'b0, 1'b1, 32'hAAAA_AAAA, 32'h0F0F_0F0F, 8'h3C, 8'h35},
        '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h8000_0001, 8'h96, 8'h35}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        for (int k = 0; k < 256; k++) begin
            @(posedge clk);
            @(negedge clk);
            oe_cap[k]  = ser_oe;
            out_cap[k] = ser_out;
        end
    endtask

    task automatic check_frame(input logic td, input logic law, input logic [31:0] conf,
                               input logic [31:0] chan, input logic [7:0] code, input string extra);
        for (int s = 0; s < 32; s++) begin
            logic [7:0] got, exp;
            logic [7:0] oes;
            string tag;
            for (int b = 0; b < 8; b++) begin
                got[7-b] = out_cap[s*8+b];
                oes[b]   = oe_cap[s*8+b];
            end
            check(oes == {8{chan[s]}}, "R8 oe", 32'(oes), 32'({8{chan[s]}}));
            if (chan[s]) begin
                if (td && conf[s]) begin
                    exp = code;
                    tag = law ? "R6 R4 R3 R7 tone" : "R5 R4 R3 R7 tone";
                end else begin
                    exp = data_for(5'(s), seed);
                    tag = td ? "R2 R7 data" : "R1 R3 R7 data";
                end
                check(got == exp, {tag, extra}, 32'(got), 32'(exp));
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_n = 1'b1; tone_dur = 1'b0; tone_freq = 1'b0;
        law_sel = 1'b0; chan_sel = '0; conf_en = '0; seed = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(!ser_oe && !ser_out, "R9 reset outputs", 32'({ser_oe, ser_out}), 32'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            tone_dur  = VECS[v].td;
            tone_freq = VECS[v].tf;
            law_sel   = VECS[v].law;
            conf_en   = VECS[v].conf;
            chan_sel  = VECS[v].chan;
            seed      = VECS[v].sd;
            frame_n   = 1'b0;
            @(posedge clk);
            @(negedge clk);
            frame_n   = 1'b1;
            // R3: flip the tone inputs after the pulse; they must be ignored
            tone_dur  = ~VECS[v].td;
            tone_freq = ~VECS[v].tf;
            capture();
            check_frame(VECS[v].td, VECS[v].law, VECS[v].conf, VECS[v].chan, VECS[v].code, "");
        end

        // R9: reset clears a latched tone and restarts the frame
        tone_dur = 1'b1; tone_freq = 1'b1; law_sel = 1'b0;
        conf_en = '1; chan_sel = '1; seed = 8'h7E;
        frame_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        frame_n = 1'b1;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!ser_oe && !ser_out, "R9 reset mid-frame", 32'({ser_oe, ser_out}), 32'd0);
        check(slot_idx == 5'd0, "R9 slot restart", 32'(slot_idx), 32'd0);
        rst = 1'b0;
        capture();
        check_frame(1'b0, 1'b0, '1, '1, 8'h9C, " R9 after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule